// File: doc/BRIEF.md
# Dual-Edge Frame Deserializer with Service-Slot Skip

This block turns a double-data-rate serial line into an 8-bit parallel word, once per frame. A data clock runs five times faster than a frame clock, and both have a 50% duty cycle. Each frame is five data-clock cycles long, which gives ten bit slots because the line is sampled on both edges. The first eight slots carry payload. The last data-clock cycle of each frame is a service cycle, and its two slots are thrown away.

Even payload bits are collected on rising data-clock edges and odd payload bits on falling edges, each in its own 4-stage shift register. A small cycle counter in each half holds its shift register still during the service cycle and uses that cycle to copy the four collected bits into a holding register. The rising half copies first, and the falling half copies half a data period later. On the next rising frame-clock edge, the interleaved holding registers are loaded into the output register. The word of frame n is therefore presented for the whole of frame n+1.

The line must already be aligned, so that slot 0 is stable at the first rising data-clock edge of each frame. Reset must be released just before a rising frame-clock edge, and that edge must coincide with a rising data-clock edge. Typical rates are a 20 MHz frame clock and a 100 MHz data clock.

Top module: `ddr_deser`

## Requirements
- R1: While rst_ni is low, par_o is 0. During the first frame after reset is released, par_o stays 0.
- R2: Within a frame, slot s is the s-th bit on the line (s = 0 first). After the frame, par_o[k] equals slot k for k = 0..7.
- R3: Even slots 0, 2, 4 and 6 are sampled on the rising data-clock edges of cycles 0 to 3 of the frame. The even holding register changes only at the rising edge of cycle 4.
- R4: Odd slots 1, 3, 5 and 7 are sampled on the falling data-clock edges of cycles 0 to 3. The odd holding register changes only at the falling edge of cycle 4, which comes after the even update.
- R5: Slots 8 and 9, the two halves of cycle 4, have no effect on par_o.
- R6: The word of frame n appears at the rising frame-clock edge that starts frame n+1. It is held for the whole of frame n+1.
- R7: par_o changes only at rising frame-clock edges. It is constant at every sample point inside a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_frame_i | input | 1 | Frame clock. A rising edge starts a frame and loads par_o. |
| clk_data_i | input | 1 | Data clock at five times the frame rate, sampled on both edges. |
| rst_ni | input | 1 | Asynchronous active-low reset. |
| ser_i | input | 1 | Aligned serial line, one slot per data-clock half period. |
| par_o | output | 8 | Parallel word of the previous frame. Bit k is slot k. |

## Verification
The bench drives a walking one, even-only and odd-only random payloads, all-zero and all-one words, and random payloads whose service slots carry random junk. It also sends pairs of identical payloads that differ only in their service slots. A design that swapped edges or reversed the shift direction would show up as misplaced or mirrored bits under the even-only and odd-only patterns. A design that shifted during the service cycle would lose bit 0 or bit 1 and let the junk reach the word. A design that loaded the output one data cycle early or late would be caught by sample points spread across every slot of the following frame: it would show a stale or half-updated word, or a change inside a frame.

// File: rtl/ddr_deser_pkg.sv
package ddr_deser_pkg;

  typedef enum logic {
    GATE_SHIFT = 1'b0,
    GATE_SKIP  = 1'b1
  } gate_e;

  localparam int unsigned FRAME_CYC_DEF = 5;

endpackage

// File: rtl/ddr_slot_gate.sv
module ddr_slot_gate
  import ddr_deser_pkg::*;
#(
  parameter int unsigned CYC     = FRAME_CYC_DEF,
  parameter bit          FALLING = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic shift_en_o,
  output logic load_o
);

  localparam int unsigned   CW   = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  gate_e         phase;

  always_comb begin
    phase = (cnt_q == LAST) ? GATE_SKIP : GATE_SHIFT;
    cnt_d = (phase == GATE_SKIP) ? '0 : cnt_q + CW'(1);
  end

  assign shift_en_o = (phase == GATE_SHIFT);
  assign load_o     = (phase == GATE_SKIP);

  // the edge the counter runs on follows the half it serves
  if (FALLING) begin : g_fall
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
    end
  end else begin : g_rise
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ddr_half_sipo.sv
module ddr_half_sipo
  import ddr_deser_pkg::*;
#(
  parameter int unsigned CYC     = FRAME_CYC_DEF,
  parameter bit          FALLING = 1'b0,
  localparam int unsigned W      = CYC - 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ser_i,
  output logic [W-1:0] hold_o
);

  logic         shift_en, load;
  logic [W-1:0] sr_q, sr_d, hold_q, hold_d;

  ddr_slot_gate #(
    .CYC    (CYC),
    .FALLING(FALLING)
  ) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_o(shift_en),
    .load_o    (load)
  );

  // newest bit enters at the top so the first one ends in bit 0
  always_comb begin
    sr_d   = shift_en ? {ser_i, sr_q[W-1:1]} : sr_q;
    hold_d = load ? sr_q : hold_q;
  end

  if (FALLING) begin : g_fall
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sr_q   <= '0;
        hold_q <= '0;
      end else begin
        sr_q   <= sr_d;
        hold_q <= hold_d;
      end
    end
  end else begin : g_rise
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sr_q   <= '0;
        hold_q <= '0;
      end else begin
        sr_q   <= sr_d;
        hold_q <= hold_d;
      end
    end
  end

  assign hold_o = hold_q;

endmodule

// File: rtl/ddr_deser.sv
module ddr_deser
  import ddr_deser_pkg::*;
#(
  parameter int unsigned CYC_PER_FRAME = FRAME_CYC_DEF,
  localparam int unsigned HALF_W       = CYC_PER_FRAME - 1,
  localparam int unsigned WORD_W       = 2 * HALF_W
) (
  input  logic              clk_frame_i,
  input  logic              clk_data_i,
  input  logic              rst_ni,
  input  logic              ser_i,
  output logic [WORD_W-1:0] par_o
);

  logic [HALF_W-1:0] hold_w [2];
  logic [WORD_W-1:0] word_w, par_q;

  // half 0: rising edge, even slots; half 1: falling edge, odd slots
  for (genvar h = 0; h < 2; h++) begin : g_half
    ddr_half_sipo #(
      .CYC    (CYC_PER_FRAME),
      .FALLING(h == 1)
    ) u_half (
      .clk_i (clk_data_i),
      .rst_ni(rst_ni),
      .ser_i (ser_i),
      .hold_o(hold_w[h])
    );
  end

  for (genvar k = 0; k < HALF_W; k++) begin : g_mix
    assign word_w[2*k]   = hold_w[0][k];
    assign word_w[2*k+1] = hold_w[1][k];
  end

  always_ff @(posedge clk_frame_i or negedge rst_ni) begin
    if (!rst_ni) par_q <= '0;
    else         par_q <= word_w;
  end

  assign par_o = par_q;

endmodule

// File: rtl/ddr_deser_chk.sv
module ddr_deser_chk #(
  parameter int unsigned CYC    = 5,
  parameter int unsigned HALF_W = 4,
  localparam int unsigned WORD_W = 2 * HALF_W,
  localparam int unsigned CW     = (CYC > 1) ? $clog2(CYC) : 1
) (
  input logic              clk_frame_i,
  input logic              clk_data_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] par_o,
  input logic [HALF_W-1:0] even_hold_i,
  input logic [HALF_W-1:0] odd_hold_i
);

  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] rise_cyc, fall_cyc;

  always_ff @(posedge clk_data_i or negedge rst_ni) begin
    if (!rst_ni)               rise_cyc <= '0;
    else if (rise_cyc == LAST) rise_cyc <= '0;
    else                       rise_cyc <= rise_cyc + CW'(1);
  end

  always_ff @(negedge clk_data_i or negedge rst_ni) begin
    if (!rst_ni)               fall_cyc <= '0;
    else if (fall_cyc == LAST) fall_cyc <= '0;
    else                       fall_cyc <= fall_cyc + CW'(1);
  end

  always @(posedge clk_frame_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (par_o == '0 && even_hold_i == '0 && odd_hold_i == '0)
        else $error("par_o or holding register not cleared in reset");
    end
  end

  assert_even_hold_R3: assert property (@(posedge clk_data_i) disable iff (!rst_ni)
    (rise_cyc != LAST) |=> $stable(even_hold_i))
    else $error("even holding register moved outside the service cycle");

  assert_odd_hold_R4: assert property (@(negedge clk_data_i) disable iff (!rst_ni)
    (fall_cyc != LAST) |=> $stable(odd_hold_i))
    else $error("odd holding register moved outside the service cycle");

  // par_o loads at the cycle-0 edge, so only the cycle-1 sample may differ
  assert_par_stable_R7: assert property (@(posedge clk_data_i) disable iff (!rst_ni)
    (rise_cyc != CW'(1)) |-> $stable(par_o))
    else $error("par_o changed inside a frame");

endmodule

bind ddr_deser ddr_deser_chk #(
  .CYC   (CYC_PER_FRAME),
  .HALF_W(HALF_W)
) u_chk (
  .clk_frame_i(clk_frame_i),
  .clk_data_i (clk_data_i),
  .rst_ni     (rst_ni),
  .par_o      (par_o),
  .even_hold_i(hold_w[0]),
  .odd_hold_i (hold_w[1])
);

// File: tb/sim_ddr_deser.sv
`timescale 1ns / 100ps
module sim_ddr_deser;

  localparam real DATA_PERIOD = 10.0;
  localparam real HALF        = DATA_PERIOD / 2.0;
  localparam real FRAME_T     = 5.0 * DATA_PERIOD;
  localparam real FIRST_FRAME = 2.0 * FRAME_T;
  localparam real WATCHDOG    = 200000.0;

  logic       clk_frame_i = 1'b0;
  logic       clk_data_i  = 1'b0;
  logic       rst_ni      = 1'b0;
  logic       ser_i       = 1'b0;
  logic [7:0] par_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0] word_q [$];
  logic [1:0] junk_q [$];
  string      tag_q  [$];

  ddr_deser u0 (
    .clk_frame_i(clk_frame_i),
    .clk_data_i (clk_data_i),
    .rst_ni     (rst_ni),
    .ser_i      (ser_i),
    .par_o      (par_o)
  );

  // both clocks from one timeline: frame rises with cycle 0, falls mid cycle 2
  initial begin
    forever begin
      for (int c = 0; c < 5; c++) begin
        clk_data_i = 1'b1;
        if (c == 0) clk_frame_i = 1'b1;
        #(HALF);
        clk_data_i = 1'b0;
        if (c == 2) clk_frame_i = 1'b0;
        #(HALF);
      end
    end
  end

  task automatic chk(input logic [7:0] exp, input string tag);
    n_run++;
    if (par_o !== exp) begin
      n_fail++;
      $display("FAIL %s: par_o=%h expected %h at %0t", tag, par_o, exp, $time);
    end
  endtask

  task automatic wait_until(input real t);
    if (t > $realtime) #(t - $realtime);
  endtask

  task automatic add(input logic [7:0] w, input logic [1:0] j, input string tag);
    word_q.push_back(w);
    junk_q.push_back(j);
    tag_q.push_back(tag);
  endtask

  initial begin
    #(WATCHDOG);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(77));
    for (int b = 0; b < 8; b++) add(8'(1 << b), 2'($urandom), "R2");
    add(8'h00, 2'b11, "R2");
    add(8'hff, 2'b00, "R2");
    for (int i = 0; i < 6; i++) add(8'($urandom) & 8'h55, 2'($urandom), "R3");
    add(8'h55, 2'b10, "R3");
    for (int i = 0; i < 6; i++) add(8'($urandom) & 8'haa, 2'($urandom), "R4");
    add(8'haa, 2'b01, "R4");
    for (int i = 0; i < 6; i++) begin
      logic [7:0] w = 8'($urandom);
      add(w, 2'b00, "R5");
      add(w, 2'b11, "R5");
    end
    add(8'h00, 2'b11, "R5");
    for (int i = 0; i < 12; i++) add(8'($urandom), 2'($urandom), "R2");

    // reset released just ahead of a frame edge
    wait_until(FIRST_FRAME - 3.0);
    rst_ni = 1'b1;

    fork
      begin : drive
        wait_until(FIRST_FRAME - HALF / 2.0);
        foreach (word_q[f]) begin
          for (int s = 0; s < 10; s++) begin
            ser_i = (s < 8) ? word_q[f][s] : junk_q[f][s-8];
            #(HALF);
          end
        end
        ser_i = 1'b0;
      end
      begin : observe
        for (int j = 0; j < 10; j++) begin
          wait_until(FIRST_FRAME + HALF / 2.0 + j * HALF);
          chk(8'h00, "R1");
        end
        foreach (word_q[f]) begin
          for (int j = 0; j < 10; j++) begin
            wait_until(FIRST_FRAME + (f + 1) * FRAME_T + HALF / 2.0 + j * HALF);
            if (j == 0)      chk(word_q[f], "R6");
            else if (j == 9) chk(word_q[f], "R7");
            else             chk(word_q[f], tag_q[f]);
          end
        end
      end
    join
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  // reset state sampled between edges while rst_ni is low
  initial begin
    for (int i = 0; i < 4; i++) begin
      wait_until(12.5 + i * 20.0);
      chk(8'h00, "R1");
    end
  end

endmodule